// File: doc/BRIEF.md
# Upper-Memory Shadow Attribute Decoder

This block steers each memory access in the 768 KiB to 1 MiB part of the legacy upper-memory window of a PC-style host bridge. The window is split into fourteen attribute slots. One slot is reserved. One covers the 64 KiB boot-firmware segment at the top. Twelve cover 16 KiB slices from 0xC0000 to 0xEFFFF. Each slot holds two enable bits, one for reads and one for writes. For every request the block asserts either a route-to-DRAM or a route-to-bus strobe. A write with its enable clear goes to the bus, so the shadow DRAM copy is never changed.

The slot attributes are packed as nibbles into seven byte-wide configuration registers, written and read through a simple offset/data port. Firmware typically copies a ROM into shadow DRAM by enabling writes only. It then enables reads and drops writes, so the copy behaves as read-only. Because the two bits are independent, reads and writes in one slot can go to different targets.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After reset all seven attribute registers read 0x00, and every access in 0xC0000–0xFFFFF is routed to the bus.
- R2: A configuration write to an offset from 0x59 to 0x5F stores its byte, and a later read of that offset returns it. Reads of any other offset return 0x00, and writes to any other offset change no routing.
- R3: Slot i is held in the register at offset 0x59 + i/2 (integer division). Even slots use bits 3:0 and odd slots use bits 7:4.
- R4: Nibble bit 0 is the read enable. A read in a slot whose bit 0 is 1 goes to DRAM, and otherwise to the bus.
- R5: Nibble bit 1 is the write enable. A write in a slot whose bit 1 is 1 goes to DRAM, and otherwise to the bus. The write enable has no effect on reads, and the read enable has no effect on writes.
- R6: Slot 1 governs the whole range 0xF0000–0xFFFFF.
- R7: Slots 2 to 13 each govern one 16 KiB slice, in ascending address order, from 0xC0000 (slot 2) up to 0xEC000–0xEFFFF (slot 13).
- R8: Slot 0 (bits 3:0 at offset 0x59) affects no address.
- R9: Any address below 0xC0000 is routed to DRAM, whatever the attributes are.
- R10: With no request valid, both route strobes are low. With a request valid, exactly one strobe is high.
- R11: The route strobes are combinational from the request, and a configuration write takes effect for a request presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| mem_valid | input | 1 | Memory request present |
| mem_write | input | 1 | 1 = write request, 0 = read request |
| mem_addr | input | 20 | Memory request byte address |
| to_dram | output | 1 | Request is routed to system DRAM |
| to_bus | output | 1 | Request is routed to the legacy bus or ROM side |

## Verification
The bench walks every slot through all four attribute values, with only that slot enabled. For each setting it presents reads and writes at the first byte, an interior byte and the last byte of every 16 KiB slice in the upper 256 KiB. A wrong nibble position, a swapped enable bit, or slice boundaries that are off by one each show up as a DRAM/bus mismatch in a neighbouring slice or in the other direction. A full 1 MiB sweep at reset separates the pass-through region below 0xC0000 from the decoded window. Writes to offsets just outside 0x59–0x5F, and the reserved slot 0, are then shown to leave routing unchanged.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

    localparam int ADDR_W      = 20;
    localparam int CFG_W       = 8;
    localparam int NIB_W       = 4;
    localparam int NUM_REGS    = 7;
    localparam int NUM_SLOTS   = NUM_REGS * (CFG_W / NIB_W);
    localparam int BANK_W      = NUM_REGS * CFG_W;
    localparam int SLOT_W      = $clog2(NUM_SLOTS);

    localparam logic [CFG_W-1:0]  CFG_BASE    = 8'h59;
    localparam logic [ADDR_W-1:0] WIN_LO      = 20'hC0000;
    localparam logic [ADDR_W-1:0] TOP_LO      = 20'hF0000;
    localparam int                SLICE_SHIFT = 14;
    localparam int                TOP_SLOT    = 1;
    localparam int                FIRST_SLICE = 2;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } region_t;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
    } attr_t;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_DRAM = 2'b01,
        ROUTE_BUS  = 2'b10
    } route_e;

    function automatic region_t locate(input logic [ADDR_W-1:0] a);
        region_t           r;
        logic [ADDR_W-1:0] off;
        logic [SLOT_W-1:0] slice;
        off   = a - WIN_LO;
        slice = SLOT_W'(off >> SLICE_SHIFT);
        r.hit  = 1'b0;
        r.slot = '0;
        if (a >= TOP_LO) begin
            r.hit  = 1'b1;
            r.slot = SLOT_W'(TOP_SLOT);
        end else if (a >= WIN_LO) begin
            r.hit  = 1'b1;
            r.slot = SLOT_W'(FIRST_SLICE) + slice;
        end
        return r;
    endfunction

endpackage

// File: rtl/shadow_attr_regs.sv
module shadow_attr_regs
    import shadow_attr_pkg::*;
#(
    parameter int               N_REGS = NUM_REGS,
    parameter logic [CFG_W-1:0] BASE   = CFG_BASE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [CFG_W-1:0]        cfg_addr,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [CFG_W-1:0]        cfg_rdata,
    output logic [N_REGS*CFG_W-1:0] bank
);

    genvar k;
    generate
        for (k = 0; k < N_REGS; k++) begin : g_reg
            localparam logic [CFG_W-1:0] OFS = CFG_W'(BASE + k);
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank[k*CFG_W +: CFG_W] <= '0;
                end else if (cfg_wr && cfg_addr == OFS) begin
                    bank[k*CFG_W +: CFG_W] <= cfg_wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        for (int j = 0; j < N_REGS; j++) begin
            if (cfg_addr == CFG_W'(BASE + j)) begin
                cfg_rdata = bank[j*CFG_W +: CFG_W];
            end
        end
    end

endmodule

// File: rtl/shadow_region_lookup.sv
module shadow_region_lookup
    import shadow_attr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);

    always_comb begin
        region = locate(addr);
    end

endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel
    import shadow_attr_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  region_t           region,
    input  logic              valid,
    input  logic              write,
    output route_e            route
);

    attr_t                   attr;
    logic [$clog2(BANK_W)-1:0] pos;

    always_comb begin
        pos  = $clog2(BANK_W)'(region.slot) << 2;
        attr = bank[pos +: 2];
        if (!valid) begin
            route = ROUTE_NONE;
        end else if (!region.hit || region.slot == '0) begin
            route = ROUTE_DRAM;
        end else if (write) begin
            route = attr.wr_en ? ROUTE_DRAM : ROUTE_BUS;
        end else begin
            route = attr.rd_en ? ROUTE_DRAM : ROUTE_BUS;
        end
    end

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
    import shadow_attr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              mem_valid,
    input  logic              mem_write,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              to_dram,
    output logic              to_bus
);

    logic [BANK_W-1:0] bank;
    region_t           region;
    route_e            route;

    shadow_attr_regs #(
        .N_REGS (NUM_REGS),
        .BASE   (CFG_BASE)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bank      (bank)
    );

    shadow_region_lookup u_lookup (
        .addr   (mem_addr),
        .region (region)
    );

    shadow_route_sel u_sel (
        .bank   (bank),
        .region (region),
        .valid  (mem_valid),
        .write  (mem_write),
        .route  (route)
    );

    assign to_dram = (route == ROUTE_DRAM);
    assign to_bus  = (route == ROUTE_BUS);

endmodule

// File: rtl/shadow_attr_checker.sv
module shadow_attr_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [7:0]  cfg_addr,
    input logic [7:0]  cfg_wdata,
    input logic [7:0]  cfg_rdata,
    input logic        mem_valid,
    input logic [19:0] mem_addr,
    input logic        to_dram,
    input logic        to_bus
);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !mem_valid |-> (!to_dram && !to_bus));

    assert_one_target_R10: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> $onehot({to_dram, to_bus}));

    assert_low_mem_dram_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_addr < 20'hC0000) |-> to_dram);

    assert_reset_bus_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && mem_valid && mem_addr >= 20'hC0000) |-> to_bus);

    assert_cfg_roundtrip_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_wr) && $past(cfg_addr) >= 8'h59 && $past(cfg_addr) <= 8'h5F
         && !cfg_wr && cfg_addr == $past(cfg_addr)) |-> cfg_rdata == $past(cfg_wdata));

endmodule

bind shadow_attr_decoder shadow_attr_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .to_dram   (to_dram),
    .to_bus    (to_bus)
);

// File: tb/test_shadow_attr_decoder.sv
`timescale 1ns/1ps
module test_shadow_attr_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        mem_valid = 1'b0;
    logic        mem_write = 1'b0;
    logic [19:0] mem_addr = '0;
    logic        to_dram;
    logic        to_bus;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic [3:0] model [14];

    always #2.5 clk = ~clk;

    shadow_attr_decoder i_shadow_attr_decoder (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_addr(mem_addr), .to_dram(to_dram), .to_bus(to_bus)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        cfg_addr = a;
        #1;
        check($sformatf("%s cfg[0x%0h]", tag, a), {24'd0, cfg_rdata}, {24'd0, exp});
    endtask

    // R3: register r holds slot 2r in bits 3:0 and slot 2r+1 in bits 7:4
    task automatic load_model();
        for (int r = 0; r < 7; r++) cfg_write(8'h59 + 8'(r), {model[2*r+1], model[2*r]});
    endtask

    function automatic bit exp_dram(input logic [19:0] a, input bit w);
        int idx;
        if (a < 20'hC0000) return 1'b1;
        if (a >= 20'hF0000) idx = 1;
        else idx = 2 + int'((a - 20'hC0000) / 20'h4000);
        if (idx == 0) return 1'b1;
        return w ? model[idx][1] : model[idx][0];
    endfunction

    task automatic route_check(input logic [19:0] a, input bit w, input string tag);
        bit e;
        mem_valid = 1'b1; mem_addr = a; mem_write = w;
        #1;
        e = exp_dram(a, w);
        check($sformatf("%s %s @0x%05h", tag, w ? "wr" : "rd", a), {30'd0, to_dram, to_bus}, {30'd0, e, ~e});
    endtask

    function automatic string region_tag(input logic [19:0] a);
        if (a < 20'hC0000) return "R9";
        if (a >= 20'hF0000) return "R6";
        return "R7";
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 14; i++) model[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values; R2: unmapped offsets read zero
        for (int r = 0; r < 7; r++) cfg_check(8'h59 + 8'(r), 8'h00, "R1");
        cfg_check(8'h58, 8'h00, "R2");
        cfg_check(8'h60, 8'h00, "R2");

        // R10: idle gives no strobe
        mem_valid = 1'b0; #1;
        check("R10 idle", {30'd0, to_dram, to_bus}, 32'd0);

        // R1 / R9: full 1 MiB sweep at reset values
        for (int k = 0; k < 64; k++) begin
            route_check(20'(k * 20'h4000 + 20'h0ABC), 1'b0, k >= 48 ? "R1" : "R9");
            route_check(20'(k * 20'h4000 + 20'h3FFF), 1'b1, k >= 48 ? "R1" : "R9");
        end
        route_check(20'hBFFFF, 1'b0, "R9");
        mem_valid = 1'b0;

        // R2: round trip through every register
        for (int r = 0; r < 7; r++) begin
            cfg_write(8'h59 + 8'(r), 8'(8'h3C + r * 8'h11));
            cfg_check(8'h59 + 8'(r), 8'(8'h3C + r * 8'h11), "R2");
        end
        load_model();

        // R3..R8: one slot at a time, all four attribute values
        for (int s = 0; s < 14; s++) begin
            for (int v = 0; v < 4; v++) begin
                for (int i = 0; i < 14; i++) model[i] = 4'h0;
                model[s] = 4'(v);
                load_model();
                cfg_check(8'h59 + 8'(s / 2), {model[s | 1], model[s & ~1]}, "R3");
                for (int k = 48; k < 64; k++) begin
                    for (int o = 0; o < 3; o++) begin
                        logic [19:0] a;
                        string t;
                        a = 20'(k * 20'h4000) + (o == 0 ? 20'h0 : (o == 1 ? 20'h1A5C : 20'h3FFF));
                        t = (s == 0) ? "R8" : region_tag(a);
                        route_check(a, 1'b0, {t, "/R4"});
                        route_check(a, 1'b1, {t, "/R5"});
                    end
                end
                route_check(20'hBFFFF, 1'b1, "R9");
                mem_valid = 1'b0;
            end
        end

        // R11: attribute change visible on the very next request
        for (int i = 0; i < 14; i++) model[i] = 4'h0;
        load_model();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 8'h5F; cfg_wdata = 8'h10;
        @(negedge clk);
        cfg_wr = 1'b0;
        model[13] = 4'h0; model[12] = 4'h0; model[13] = 4'h1;
        route_check(20'hEC123, 1'b0, "R11");
        route_check(20'hEC123, 1'b1, "R11");
        mem_valid = 1'b0;

        // R2: writes outside 0x59..0x5F change no routing
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_check(8'h59, 8'h00, "R2");
        route_check(20'hF8000, 1'b0, "R2");
        route_check(20'hC0000, 1'b1, "R2");
        mem_valid = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule